// File: doc/BRIEF.md
# Dual-Issue Pairing Logic

This block sits between a small in-order pending queue and two execution pipes. Every cycle it looks at the two oldest queued instructions: the older one and the younger one. It decides whether both of them issue, only the older one, or neither. It also decides which instruction goes to which pipe. Each instruction arrives already decoded into a class code, up to two source register numbers with per-source valid bits, and (for the older one) a destination register. An external register-ready vector says which registers have results still pending from earlier in-flight instructions.

Pairing follows a fixed class table. Multiply/accumulate and multi-cycle work may only use pipe 0, and system-class operations always go alone. There is one load/store pipe, so two memory operations never pair. The younger instruction may read the older one's result in the same cycle when the older one is a single-cycle ALU, multiply/accumulate or SIMD operation, because forwarding delivers the value in time. A load or multi-cycle producer holds the dependent younger instruction back by one cycle.

The decision is registered: the outputs reflect the inputs presented at the previous rising clock edge.

Top module: `dual_issue_pair`

## Requirements
- R1: After a synchronous active-low reset, `issue_cnt` is 0 and `pipe_swap` is 0. Each decision appears on the outputs one clock after its inputs are sampled. `issue_cnt` only ever takes the values 0, 1 or 2.
- R2: `issue_cnt` is 0 when the older instruction is not valid, or when any valid source of the older instruction is not ready (`reg_ready` bit clear).
- R3: The system class (code 5) never pairs, whether it is in the older or the younger slot.
- R4: Class codes are: 0 ALU, 1 load/store, 2 multiply/accumulate, 3 multi-cycle, 4 SIMD, 5 system. These unordered pairs dual-issue when no hazard blocks them: ALU with ALU, load/store, mul/acc or SIMD; mul/acc with load/store or SIMD; SIMD with SIMD or load/store.
- R5: Load/store with load/store, mul/acc with mul/acc, and multi-cycle with any class issue only the older instruction.
- R6: `pipe_swap` is 1 only when two instructions issue and the younger one is pipe-0-restricted (mul/acc) while the older one is not. The younger instruction then goes to pipe 0 and the older to pipe 1. Otherwise the older instruction takes pipe 0.
- R7: A younger instruction with a valid source equal to the older instruction's valid destination does not pair when the older class is load/store or multi-cycle.
- R8: The same dependency does not prevent pairing when the older class is ALU, mul/acc or SIMD.
- R9: Only the older instruction issues when the younger one is not valid, or when any valid younger source is not ready.
- R10: A source whose valid bit is clear is ignored, both for readiness and for the dependency cross-check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| old_vld | input | 1 | Older queue slot holds an instruction |
| old_cls | input | 3 | Older instruction class code |
| old_src | input | NSRC*REG_W | Older source register numbers, source i at bits i*REG_W |
| old_src_vld | input | NSRC | Older per-source valid bits |
| old_dst | input | REG_W | Older destination register |
| old_dst_vld | input | 1 | Older instruction writes a register |
| yng_vld | input | 1 | Younger queue slot holds an instruction |
| yng_cls | input | 3 | Younger instruction class code |
| yng_src | input | NSRC*REG_W | Younger source register numbers |
| yng_src_vld | input | NSRC | Younger per-source valid bits |
| reg_ready | input | 2**REG_W | Per-register ready vector from the scoreboard |
| issue_cnt | output | 2 | Number of instructions issued (0, 1, 2) |
| pipe_swap | output | 1 | 1: younger to pipe 0 and older to pipe 1 |

## Verification
On every cycle, the assertions check the following:
- the issue count never reaches 3;
- a swap only accompanies a dual issue;
- an empty older slot yields a zero count;
- system-class operations, load/store pairs and dependencies on loads never dual-issue.

Other behaviour is shown only by the bench's scenarios, which compare the outputs with an independent model under random classes, registers and ready vectors:
- the exact set of allowed pairs;
- forwarding-based pairing of dependent instructions;
- that invalid sources are ignored;
- the exact swap condition.

// File: rtl/pair_pkg.sv
// Package: shared class codes and pairing tables for the dual-issue logic.
// Assumes class codes fit in 3 bits; codes 6 and 7 are treated as unpairable.
package pair_pkg;

    typedef enum logic [2:0] {
        CLS_ALU   = 3'd0,
        CLS_MEM   = 3'd1,
        CLS_MAC   = 3'd2,
        CLS_MULTI = 3'd3,
        CLS_SIMD  = 3'd4,
        CLS_SYS   = 3'd5
    } iclass_e;

    // Bit k of the result is set when class c may pair with class k.
    function automatic logic [7:0] partner_mask(input logic [2:0] c);
        logic [7:0] m;
        case (c)
            3'd0:    m = 8'b0001_0111;  // ALU: ALU, MEM, MAC, SIMD
            3'd1:    m = 8'b0001_0101;  // MEM: ALU, MAC, SIMD
            3'd2:    m = 8'b0001_0011;  // MAC: ALU, MEM, SIMD
            3'd4:    m = 8'b0001_0111;  // SIMD: ALU, MEM, MAC, SIMD
            default: m = 8'b0000_0000;  // MULTI, SYS, unused codes
        endcase
        return m;
    endfunction

    // Classes that may only execute in pipe 0.
    function automatic logic pipe0_only(input logic [2:0] c);
        return (c == CLS_MAC) || (c == CLS_MULTI);
    endfunction

    // Producers whose result cannot be forwarded to a same-cycle partner.
    function automatic logic late_result(input logic [2:0] c);
        return (c == CLS_MEM) || (c == CLS_MULTI);
    endfunction

endpackage

// File: rtl/pair_class_rules.sv
// Module: class-based pairing rules.
// Decides from the two class codes alone whether the pair is structurally
// legal and whether pipe assignment must be swapped. Purely combinational.
module pair_class_rules
    import pair_pkg::*;
(
    input  logic [2:0] old_cls,
    input  logic [2:0] yng_cls,
    output logic       pair_ok,
    output logic       want_swap
);

    logic [7:0] old_mask;

    // Look up which younger classes the older class accepts.
    always_comb begin
        old_mask = partner_mask(old_cls);
        pair_ok  = old_mask[yng_cls];
    end

    // Younger restricted to pipe 0 while older is free: swap the slots.
    always_comb begin
        want_swap = pipe0_only(yng_cls) && !pipe0_only(old_cls);
    end

endmodule

// File: rtl/pair_hazard_check.sv
// Module: register hazard checks for the two oldest instructions.
// Checks readiness of every valid source against the scoreboard vector and
// cross-checks younger sources against the older destination. Combinational.
module pair_hazard_check #(
    parameter int REG_W = 4,
    parameter int NSRC  = 2,
    localparam int NREGS = 1 << REG_W
) (
    input  logic [NSRC*REG_W-1:0] old_src,
    input  logic [NSRC-1:0]       old_src_vld,
    input  logic [REG_W-1:0]      old_dst,
    input  logic                  old_dst_vld,
    input  logic [NSRC*REG_W-1:0] yng_src,
    input  logic [NSRC-1:0]       yng_src_vld,
    input  logic [NREGS-1:0]      reg_ready,
    output logic                  old_rdy,
    output logic                  yng_rdy,
    output logic                  yng_dep
);

    logic [NSRC-1:0] old_ok;
    logic [NSRC-1:0] yng_ok;
    logic [NSRC-1:0] dep_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [REG_W-1:0] o_reg;
        logic [REG_W-1:0] y_reg;
        assign o_reg = old_src[i*REG_W +: REG_W];
        assign y_reg = yng_src[i*REG_W +: REG_W];

        // Per-source readiness and dependency match.
        always_comb begin
            old_ok[i]  = !old_src_vld[i] || reg_ready[o_reg];
            yng_ok[i]  = !yng_src_vld[i] || reg_ready[y_reg];
            dep_hit[i] = yng_src_vld[i] && old_dst_vld && (y_reg == old_dst);
        end
    end

    // Reduce per-source results.
    always_comb begin
        old_rdy = &old_ok;
        yng_rdy = &yng_ok;
        yng_dep = |dep_hit;
    end

endmodule

// File: rtl/dual_issue_pair.sv
// Module: dual-issue pairing decision, registered.
// Combines class rules and register hazards into an issue count and a pipe
// swap flag, registered once. Assumes the scoreboard vector already covers
// all older in-flight instructions; the older queue slot is not in it.
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int NSRC  = 2,
    localparam int NREGS = 1 << REG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  old_vld,
    input  logic [2:0]            old_cls,
    input  logic [NSRC*REG_W-1:0] old_src,
    input  logic [NSRC-1:0]       old_src_vld,
    input  logic [REG_W-1:0]      old_dst,
    input  logic                  old_dst_vld,
    input  logic                  yng_vld,
    input  logic [2:0]            yng_cls,
    input  logic [NSRC*REG_W-1:0] yng_src,
    input  logic [NSRC-1:0]       yng_src_vld,
    input  logic [NREGS-1:0]      reg_ready,
    output logic [1:0]            issue_cnt,
    output logic                  pipe_swap
);

    logic       pair_ok, want_swap;
    logic       old_rdy, yng_rdy, yng_dep;
    logic       dep_block;
    logic [1:0] cnt_d;
    logic       swap_d;

    pair_class_rules u_rules (
        .old_cls   (old_cls),
        .yng_cls   (yng_cls),
        .pair_ok   (pair_ok),
        .want_swap (want_swap)
    );

    pair_hazard_check #(.REG_W(REG_W), .NSRC(NSRC)) u_hazard (
        .old_src     (old_src),
        .old_src_vld (old_src_vld),
        .old_dst     (old_dst),
        .old_dst_vld (old_dst_vld),
        .yng_src     (yng_src),
        .yng_src_vld (yng_src_vld),
        .reg_ready   (reg_ready),
        .old_rdy     (old_rdy),
        .yng_rdy     (yng_rdy),
        .yng_dep     (yng_dep)
    );

    // Choose issue count from validity, readiness, class rules and dependency.
    always_comb begin
        dep_block = yng_dep && late_result(old_cls);
        if (!old_vld || !old_rdy)
            cnt_d = 2'd0;
        else if (!yng_vld || !pair_ok || !yng_rdy || dep_block)
            cnt_d = 2'd1;
        else
            cnt_d = 2'd2;
        swap_d = (cnt_d == 2'd2) && want_swap;
    end

    // Register the decision for the issue stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_cnt <= 2'd0;
            pipe_swap <= 1'b0;
        end else begin
            issue_cnt <= cnt_d;
            pipe_swap <= swap_d;
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt != 2'd3);

    // R6
    swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_swap |-> (issue_cnt == 2'd2));

    // R2
    old_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !old_vld |=> (issue_cnt == 2'd0));

    // R3
    sys_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_cls == CLS_SYS || yng_cls == CLS_SYS) |=> (issue_cnt != 2'd2));

    // R5
    mem_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_cls == CLS_MEM && yng_cls == CLS_MEM) |=> (issue_cnt != 2'd2));

    // R7
    late_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_dep && (old_cls == CLS_MEM || old_cls == CLS_MULTI))
        |=> (issue_cnt != 2'd2));

endmodule

// File: tb/dual_issue_pair_bench.sv
// Bench: directed corner cases plus seeded random stimulus for the pairing logic.
module dual_issue_pair_bench;

    typedef struct {
        logic       v;
        logic [2:0] c;
        logic [3:0] s0;
        logic [3:0] s1;
        logic [1:0] sv;
        logic [3:0] d;
        logic       dv;
    } ins_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        old_vld, old_dst_vld, yng_vld;
    logic [2:0]  old_cls, yng_cls;
    logic [7:0]  old_src, yng_src;
    logic [1:0]  old_src_vld, yng_src_vld;
    logic [3:0]  old_dst;
    logic [15:0] reg_ready;
    logic [1:0]  issue_cnt;
    logic        pipe_swap;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dual_issue_pair u_dual_issue_pair (
        .clk(clk), .rst_n(rst_n),
        .old_vld(old_vld), .old_cls(old_cls), .old_src(old_src),
        .old_src_vld(old_src_vld), .old_dst(old_dst), .old_dst_vld(old_dst_vld),
        .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_src(yng_src),
        .yng_src_vld(yng_src_vld), .reg_ready(reg_ready),
        .issue_cnt(issue_cnt), .pipe_swap(pipe_swap)
    );

    function automatic ins_t mk(input logic v, input logic [2:0] c,
                                input logic [3:0] s0, input logic [3:0] s1,
                                input logic [1:0] sv, input logic [3:0] d,
                                input logic dv);
        ins_t x;
        x.v = v; x.c = c; x.s0 = s0; x.s1 = s1; x.sv = sv; x.d = d; x.dv = dv;
        return x;
    endfunction

    // Allowed unordered pairs from the class table (R4).
    function automatic bit can_pair(input logic [2:0] a, input logic [2:0] b);
        bit ab = 0;
        if ((a == 0 && b == 0) || (a == 4 && b == 4)) ab = 1;
        if ((a == 0 && b == 1) || (a == 1 && b == 0)) ab = 1;
        if ((a == 0 && b == 2) || (a == 2 && b == 0)) ab = 1;
        if ((a == 0 && b == 4) || (a == 4 && b == 0)) ab = 1;
        if ((a == 2 && b == 1) || (a == 1 && b == 2)) ab = 1;
        if ((a == 2 && b == 4) || (a == 4 && b == 2)) ab = 1;
        if ((a == 4 && b == 1) || (a == 1 && b == 4)) ab = 1;
        return ab;
    endfunction

    function automatic bit srcs_ready(input ins_t x, input logic [15:0] rdy);
        return (!x.sv[0] || rdy[x.s0]) && (!x.sv[1] || rdy[x.s1]);
    endfunction

    function automatic int exp_cnt(input ins_t o, input ins_t y, input logic [15:0] rdy);
        bit dep;
        if (!o.v || !srcs_ready(o, rdy)) return 0;
        if (!y.v || !srcs_ready(y, rdy) || !can_pair(o.c, y.c)) return 1;
        dep = o.dv && ((y.sv[0] && y.s0 == o.d) || (y.sv[1] && y.s1 == o.d));
        if (dep && (o.c == 1 || o.c == 3)) return 1;
        return 2;
    endfunction

    function automatic bit exp_swap(input ins_t o, input ins_t y, input logic [15:0] rdy);
        return (exp_cnt(o, y, rdy) == 2) && (y.c == 2) && (o.c != 2);
    endfunction

    // Drive one pair, wait for the registered result, compare.
    task automatic run(input ins_t o, input ins_t y, input logic [15:0] rdy,
                       input string tag);
        int  ec;
        bit  es;
        old_vld = o.v; old_cls = o.c; old_src = {o.s1, o.s0};
        old_src_vld = o.sv; old_dst = o.d; old_dst_vld = o.dv;
        yng_vld = y.v; yng_cls = y.c; yng_src = {y.s1, y.s0};
        yng_src_vld = y.sv; reg_ready = rdy;
        ec = exp_cnt(o, y, rdy);
        es = exp_swap(o, y, rdy);
        @(posedge clk);
        @(negedge clk);
        tests++;
        if (int'(issue_cnt) != ec || pipe_swap != es) begin
            fails++;
            $display("FAIL %s: cnt=%0d swap=%0d expected cnt=%0d swap=%0d",
                     tag, issue_cnt, pipe_swap, ec, es);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] all_rdy;
        all_rdy = 16'hFFFF;
        void'($urandom(32'd20240611));
        old_vld = 1; old_cls = 0; old_src = 0; old_src_vld = 0; old_dst = 0;
        old_dst_vld = 0; yng_vld = 1; yng_cls = 0; yng_src = 0; yng_src_vld = 0;
        reg_ready = all_rdy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (issue_cnt != 2'd0 || pipe_swap != 1'b0) begin
            fails++;
            $display("FAIL R1 reset: cnt=%0d swap=%0d expected cnt=0 swap=0", issue_cnt, pipe_swap);
        end
        rst_n = 1'b1;

        // R2: older invalid, older source not ready
        run(mk(0,0,1,2,3,5,1), mk(1,0,1,2,3,6,1), all_rdy, "R2 older invalid");
        run(mk(1,0,3,2,2'b01,5,1), mk(1,0,1,2,3,6,1), 16'hFFF7, "R2 older src busy");
        // R10: busy register named only by an invalid source
        run(mk(1,0,3,3,2'b00,5,1), mk(1,0,1,2,3,6,1), 16'hFFF7, "R10 invalid src ignored");
        run(mk(1,1,1,2,3,5,1), mk(1,0,5,2,2'b10,6,1), all_rdy, "R10 invalid src no dep");
        // R3: system class in either slot
        run(mk(1,5,1,2,3,5,1), mk(1,0,1,2,3,6,1), all_rdy, "R3 sys older");
        run(mk(1,0,1,2,3,5,1), mk(1,5,1,2,3,6,1), all_rdy, "R3 sys younger");
        // R4: allowed pairs
        run(mk(1,2,1,2,3,5,1), mk(1,4,1,2,3,6,1), all_rdy, "R4 mac+simd");
        run(mk(1,0,1,2,3,5,1), mk(1,1,1,2,3,6,1), all_rdy, "R4 alu+mem");
        run(mk(1,4,1,2,3,5,1), mk(1,4,1,2,3,6,1), all_rdy, "R4 simd+simd");
        // R5: forbidden pairs
        run(mk(1,1,1,2,3,5,1), mk(1,1,1,2,3,6,1), all_rdy, "R5 mem+mem");
        run(mk(1,2,1,2,3,5,1), mk(1,2,1,2,3,6,1), all_rdy, "R5 mac+mac");
        run(mk(1,3,1,2,3,5,1), mk(1,0,1,2,3,6,1), all_rdy, "R5 multi+alu");
        // R6: younger mac swaps to pipe 0
        run(mk(1,0,1,2,3,5,1), mk(1,2,1,2,3,6,1), all_rdy, "R6 alu+mac swap");
        run(mk(1,4,1,2,3,5,1), mk(1,2,1,2,3,6,1), all_rdy, "R6 simd+mac swap");
        // R7: dependent on load / multi-cycle
        run(mk(1,1,1,2,3,7,1), mk(1,0,7,2,2'b01,6,1), all_rdy, "R7 dep on load");
        // R8: dependent on forwardable producer
        run(mk(1,0,1,2,3,7,1), mk(1,0,7,2,2'b01,6,1), all_rdy, "R8 dep on alu");
        run(mk(1,2,1,2,3,7,1), mk(1,4,2,7,2'b10,6,1), all_rdy, "R8 dep on mac");
        // R9: younger invalid, younger source not ready
        run(mk(1,0,1,2,3,5,1), mk(0,0,1,2,3,6,1), all_rdy, "R9 younger invalid");
        run(mk(1,0,1,2,3,5,1), mk(1,0,9,2,2'b01,6,1), 16'hFDFF, "R9 younger src busy");

        for (int k = 0; k < 400; k++) begin
            ins_t o, y;
            logic [15:0] rdy;
            o = mk(($urandom % 8) != 0, 3'($urandom % 6), 4'($urandom % 4), 4'($urandom % 4),
                   2'($urandom), 4'($urandom % 4), 1'($urandom));
            y = mk(($urandom % 8) != 0, 3'($urandom % 6), 4'($urandom % 4), 4'($urandom % 4),
                   2'($urandom), 4'($urandom % 4), 1'($urandom));
            rdy = ~16'($urandom & $urandom & $urandom);
            run(o, y, rdy, "random R4/R7/R8");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule